// File: doc/BRIEF.md
# Path-Sensitive Indirect Jump Target Cache

This block predicts where an indirect jump will go. Such a jump can land in a different place on each path that leads to it. The block keeps a global record of recent branch directions. On every lookup it mixes that record with the fetch address to pick a set in a two-way table. Each way holds a valid flag, a tag and a target address. A tagged hit on an indirect jump returns the cached target and the way that held it. Any other lookup passes through the target that the branch target buffer supplies on an input port.

The lookup reports the set index and tag it computed, and the pipeline carries them alongside the jump. When the jump resolves, those two values come back with the real target on the resolve port. A resolve that matches a stored tag overwrites that entry's target in place. Otherwise the resolve allocates a way: an empty way first, and the least recently used way once the set is full. Because the path history is part of both the index and the tag, one jump can hold several live targets, one for each path that leads to it.

Top module: `ind_tgt_cache`

## Requirements
- R1: After reset every entry is invalid and the history register reads zero, so no lookup hits until a resolve has written an entry.
- R2: When `hist_upd_valid` is high, the history shifts one place toward its MSB and `hist_upd_taken` (1 = taken, 0 = not taken) enters at bit 0. When `hist_upd_valid` is low, the history holds.
- R3: The set index is the word address bits `lk_pc[IDX_W+1:2]` XORed with history bits `[IDX_W-1:0]`. The tag is `lk_pc[PC_W-1:IDX_W+2]` XORed with the remaining upper history bits, zero-extended and aligned to the tag LSB. Both appear on `lk_idx` and `lk_tag` in the same cycle as the lookup.
- R4: A lookup with `lk_valid` and `lk_is_ind` both high hits when a valid way in the indexed set holds a matching tag. It then drives `lk_hit`=1, `lk_way` set to that way (0 or 1), and `lk_target` set to the stored target, all combinationally.
- R5: On a miss, or when `lk_is_ind` is low, `lk_hit` is 0 and `lk_target` equals `lk_btb_target`.
- R6: A resolve whose index and tag match a valid way replaces only that way's target. The other way keeps its contents.
- R7: A resolve that matches no way writes the lowest-numbered invalid way of the set. If both ways are valid, it writes the way named by the set's LRU bit.
- R8: A lookup hit on way w, or a resolve write to way w, makes the other way the set's next victim. If both happen to the same set in one cycle, the resolve decides.
- R9: The same jump address under two different histories maps to separate entries, each with its own target.
- R10: While `lk_valid` is low, `lk_hit` is 0, `lk_target` equals `lk_btb_target`, and the LRU state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| hist_upd_valid | input | 1 | Shift a resolved direction into the history |
| hist_upd_taken | input | 1 | Direction to shift in: 1 taken, 0 not taken |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W-2 | Word address of the jump (byte offset dropped) |
| lk_is_ind | input | 1 | The jump is indirect |
| lk_btb_target | input | TGT_W | Fallback target from the branch target buffer |
| lk_hit | output | 1 | Tagged hit on an indirect jump |
| lk_way | output | 1 | Way that hit |
| lk_target | output | TGT_W | Final predicted target |
| lk_idx | output | IDX_W | Set index computed for this lookup |
| lk_tag | output | PC_W-2-IDX_W | Tag computed for this lookup |
| rs_valid | input | 1 | Resolve write this cycle |
| rs_idx | input | IDX_W | Index captured at lookup |
| rs_tag | input | PC_W-2-IDX_W | Tag captured at lookup |
| rs_target | input | TGT_W | Actual target of the resolved jump |
| ghist | output | HIST_W | Current global history |

## Verification
The bench fills one set through a sequence of distinct jumps that all hash into it. The sequence forces eviction of the way that was idle longest. A design that ignores recency, or replaces a valid way while an empty one exists, evicts the wrong jump, and a later lookup misses where a hit is expected. A second resolve for a jump already present must overwrite that entry. An implementation that allocates a new way instead would evict a neighbour and leave a duplicate tag. Further checks issue lookups for non-indirect jumps, lookups with the request line idle, and the same jump under a changed history. A design that leaks cached targets into any of these, or that drops history from the index, returns the wrong target. Every lookup also compares `lk_idx` and `lk_tag` with the hash computed independently in the bench. Finally, a reset in the middle of the run must make entries that hit just before it miss.

// File: rtl/itc_pkg.sv
package itc_pkg;
  // The replacement state is one bit per set, which only covers two ways.
  localparam int ITC_WAYS = 2;
  localparam int WAY_W    = 1;
  typedef logic [WAY_W-1:0] way_t;
endpackage

// File: rtl/itc_ghist.sv
module itc_ghist #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              upd_taken,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q, hist_d;

  always_comb begin
    hist_d = hist_q;
    if (upd_en) hist_d = {hist_q[HIST_W-2:0], upd_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/itc_hash.sv
module itc_hash #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = PC_W - 2 - IDX_W
) (
  input  logic [PC_W-1:2]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int HI_W = HIST_W - IDX_W;

  assign idx = pc[IDX_W+1:2] ^ hist[IDX_W-1:0];

  generate
    if (HI_W > 0) begin : g_fold
      assign tag = pc[PC_W-1:IDX_W+2] ^ {{(TAG_W-HI_W){1'b0}}, hist[HIST_W-1:IDX_W]};
    end else begin : g_plain
      assign tag = pc[PC_W-1:IDX_W+2];
    end
  endgenerate
endmodule

// File: rtl/itc_way.sv
module itc_way #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int TGT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_tgt,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_tgt,
  input  logic [IDX_W-1:0] ck_idx,
  output logic             ck_valid,
  output logic [TAG_W-1:0] ck_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]  vld_q, vld_d;
  logic [TAG_W-1:0] tag_q [SETS];
  logic [TGT_W-1:0] tgt_q [SETS];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Payload carries no reset; the valid bit guards it.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_tgt   = tgt_q[rd_idx];
  assign ck_valid = vld_q[ck_idx];
  assign ck_tag   = tag_q[ck_idx];
endmodule

// File: rtl/itc_lru.sv
module itc_lru
  import itc_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_touch,
  input  logic [IDX_W-1:0] lk_idx,
  input  way_t             lk_way,
  input  logic             wr_touch,
  input  logic [IDX_W-1:0] wr_idx,
  input  way_t             wr_way,
  input  logic [IDX_W-1:0] rd_idx,
  output way_t             rd_victim
);
  localparam int SETS = 1 << IDX_W;

  way_t lru_q [SETS];
  way_t lru_d [SETS];

  // Each entry names the way to replace next; the write touch is applied last.
  always_comb begin
    for (int s = 0; s < SETS; s++) lru_d[s] = lru_q[s];
    if (lk_touch) lru_d[lk_idx] = ~lk_way;
    if (wr_touch) lru_d[wr_idx] = ~wr_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= lru_d[s];
    end
  end

  assign rd_victim = lru_q[rd_idx];
endmodule

// File: rtl/ind_tgt_cache.sv
module ind_tgt_cache
  import itc_pkg::*;
#(
  parameter  int PC_W   = 32,
  parameter  int HIST_W = 8,
  parameter  int IDX_W  = 6,
  parameter  int TGT_W  = 32,
  localparam int TAG_W  = PC_W - 2 - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hist_upd_valid,
  input  logic              hist_upd_taken,
  input  logic              lk_valid,
  input  logic [PC_W-1:2]   lk_pc,
  input  logic              lk_is_ind,
  input  logic [TGT_W-1:0]  lk_btb_target,
  output logic              lk_hit,
  output logic              lk_way,
  output logic [TGT_W-1:0]  lk_target,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              rs_valid,
  input  logic [IDX_W-1:0]  rs_idx,
  input  logic [TAG_W-1:0]  rs_tag,
  input  logic [TGT_W-1:0]  rs_target,
  output logic [HIST_W-1:0] ghist
);
  logic [ITC_WAYS-1:0] rd_valid, ck_valid, wr_en_vec;
  logic [TAG_W-1:0]    rd_tag [ITC_WAYS];
  logic [TGT_W-1:0]    rd_tgt [ITC_WAYS];
  logic [TAG_W-1:0]    ck_tag [ITC_WAYS];
  logic [ITC_WAYS-1:0] lk_hit_vec, rs_hit_vec;
  way_t                hit_way, rs_match_way, free_way, lru_victim, victim;
  logic                rs_any, any_free;
  logic [TGT_W-1:0]    hit_tgt;

  itc_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .upd_en(hist_upd_valid),
    .upd_taken(hist_upd_taken), .hist(ghist)
  );

  itc_hash #(.PC_W(PC_W), .HIST_W(HIST_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_hash (
    .pc(lk_pc), .hist(ghist), .idx(lk_idx), .tag(lk_tag)
  );

  generate
    for (genvar w = 0; w < ITC_WAYS; w++) begin : g_way
      itc_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_way (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_vec[w]), .wr_idx(rs_idx), .wr_tag(rs_tag), .wr_tgt(rs_target),
        .rd_idx(lk_idx), .rd_valid(rd_valid[w]), .rd_tag(rd_tag[w]), .rd_tgt(rd_tgt[w]),
        .ck_idx(rs_idx), .ck_valid(ck_valid[w]), .ck_tag(ck_tag[w])
      );
    end
  endgenerate

  // Lookup side: per-way tag compare, then target select.
  always_comb begin
    hit_way = '0;
    hit_tgt = lk_btb_target;
    for (int w = 0; w < ITC_WAYS; w++) begin
      lk_hit_vec[w] = lk_valid & lk_is_ind & rd_valid[w] & (rd_tag[w] == lk_tag);
      if (lk_hit_vec[w]) begin
        hit_way = way_t'(w);
        hit_tgt = rd_tgt[w];
      end
    end
  end

  assign lk_hit    = |lk_hit_vec;
  assign lk_way    = hit_way;
  assign lk_target = hit_tgt;

  // Resolve side: update in place, else empty way, else LRU.
  always_comb begin
    rs_match_way = '0;
    free_way     = '0;
    any_free     = 1'b0;
    for (int w = 0; w < ITC_WAYS; w++) begin
      rs_hit_vec[w] = ck_valid[w] & (ck_tag[w] == rs_tag);
      if (rs_hit_vec[w]) rs_match_way = way_t'(w);
    end
    for (int w = ITC_WAYS - 1; w >= 0; w--) begin
      if (!ck_valid[w]) begin
        free_way = way_t'(w);
        any_free = 1'b1;
      end
    end
    rs_any = |rs_hit_vec;
    if (rs_any)        victim = rs_match_way;
    else if (any_free) victim = free_way;
    else               victim = lru_victim;
    for (int w = 0; w < ITC_WAYS; w++) begin
      wr_en_vec[w] = rs_valid & (victim == way_t'(w));
    end
  end

  itc_lru #(.IDX_W(IDX_W)) u_lru (
    .clk(clk), .rst_n(rst_n),
    .lk_touch(lk_hit), .lk_idx(lk_idx), .lk_way(hit_way),
    .wr_touch(rs_valid), .wr_idx(rs_idx), .wr_way(victim),
    .rd_idx(rs_idx), .rd_victim(lru_victim)
  );
endmodule

// File: rtl/ind_tgt_cache_chk.sv
module ind_tgt_cache_chk #(
  parameter int HIST_W = 8,
  parameter int TGT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hist_upd_valid,
  input logic              hist_upd_taken,
  input logic [HIST_W-1:0] ghist,
  input logic              lk_valid,
  input logic              lk_is_ind,
  input logic              lk_hit,
  input logic [TGT_W-1:0]  lk_target,
  input logic [TGT_W-1:0]  lk_btb_target,
  input logic              rs_valid
);
  logic seen_fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_fill <= 1'b0;
    else if (rs_valid) seen_fill <= 1'b1;
  end

  assert_no_hit_before_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_fill |-> !lk_hit);

  assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hist_upd_valid |=> ghist == {$past(ghist[HIST_W-2:0]), $past(hist_upd_taken)});

  assert_hist_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hist_upd_valid |=> $stable(ghist));

  assert_btb_fallback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_target == lk_btb_target);

  assert_hit_needs_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_is_ind) |-> !lk_hit);
endmodule

bind ind_tgt_cache ind_tgt_cache_chk #(.HIST_W(HIST_W), .TGT_W(TGT_W)) u_chk (.*);

// File: tb/ind_tgt_cache_test.sv
module ind_tgt_cache_test;
  localparam int PC_W = 32, HIST_W = 8, IDX_W = 6, TGT_W = 32;
  localparam int TAG_W = PC_W - 2 - IDX_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hist_upd_valid = 1'b0, hist_upd_taken = 1'b0;
  logic lk_valid = 1'b0, lk_is_ind = 1'b0;
  logic [PC_W-1:2] lk_pc = '0;
  logic [TGT_W-1:0] lk_btb_target = '0;
  logic lk_hit, lk_way;
  logic [TGT_W-1:0] lk_target;
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic rs_valid = 1'b0;
  logic [IDX_W-1:0] rs_idx = '0;
  logic [TAG_W-1:0] rs_tag = '0;
  logic [TGT_W-1:0] rs_target = '0;
  logic [HIST_W-1:0] ghist;

  ind_tgt_cache uut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [HIST_W-1:0] mhist = '0;
  logic [IDX_W-1:0] cap_idx;
  logic [TAG_W-1:0] cap_tag;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 1'b0; lk_is_ind = 1'b0; rs_valid = 1'b0; hist_upd_valid = 1'b0;
  endtask

  // R3: the bench's own hash of address and history.
  task automatic lookup(input logic [31:0] pc, input bit ind, input logic [31:0] btb,
                        input bit ehit, input bit eway, input logic [31:0] etgt, input string req);
    logic [IDX_W-1:0] xi;
    logic [TAG_W-1:0] xt;
    @(negedge clk);
    idle();
    lk_valid = 1'b1; lk_is_ind = ind; lk_pc = pc[31:2]; lk_btb_target = btb;
    #1;
    xi = pc[7:2] ^ mhist[5:0];
    xt = pc[31:8] ^ {22'b0, mhist[7:6]};
    chk(lk_idx == xi, "R3 index", 64'(lk_idx), 64'(xi));
    chk(lk_tag == xt, "R3 tag", 64'(lk_tag), 64'(xt));
    chk(lk_hit == ehit, {req, " hit"}, 64'(lk_hit), 64'(ehit));
    if (ehit) chk(lk_way == eway, {req, " way"}, 64'(lk_way), 64'(eway));
    chk(lk_target == etgt, {req, " target"}, 64'(lk_target), 64'(etgt));
    cap_idx = lk_idx;
    cap_tag = lk_tag;
  endtask

  task automatic resolve(input logic [31:0] tgt);
    @(negedge clk);
    idle();
    rs_valid = 1'b1; rs_idx = cap_idx; rs_tag = cap_tag; rs_target = tgt;
  endtask

  task automatic shift(input bit t);
    @(negedge clk);
    idle();
    hist_upd_valid = 1'b1; hist_upd_taken = t;
    mhist = {mhist[HIST_W-2:0], t};
  endtask

  typedef struct packed {
    logic [1:0]  op;   // 0 lookup, 1 resolve, 2 history shift
    logic [31:0] pc;
    logic        ind;
    logic [31:0] btb;
    logic [31:0] val;  // lookup: expected target; resolve: written target; shift: taken bit
    logic        ehit;
    logic        eway;
  } row_t;

  localparam logic [31:0] PA = 32'h0000_1040, PCc = 32'h0002_1048,
                          PD = 32'h0004_1048, PE = 32'h0006_1048;

  localparam row_t TBL [27] = '{
    '{2'd0, PA,  1'b1, 32'hB000_0000, 32'hB000_0000, 1'b0, 1'b0}, // R1 R5 empty table
    '{2'd1, PA,  1'b0, 32'h0,         32'h8000_0001, 1'b0, 1'b0}, // R7 fill way0
    '{2'd0, PA,  1'b1, 32'hB000_0001, 32'h8000_0001, 1'b1, 1'b0}, // R4
    '{2'd0, PA,  1'b0, 32'hB000_0011, 32'hB000_0011, 1'b0, 1'b0}, // R5 non-indirect
    '{2'd2, PA,  1'b0, 32'h0,         32'h1,         1'b0, 1'b0}, // history -> 1
    '{2'd0, PA,  1'b1, 32'hB000_0002, 32'hB000_0002, 1'b0, 1'b0}, // R9 new path misses
    '{2'd1, PA,  1'b0, 32'h0,         32'h8000_0002, 1'b0, 1'b0},
    '{2'd0, PA,  1'b1, 32'hB000_0002, 32'h8000_0002, 1'b1, 1'b0}, // R9 second target
    '{2'd2, PA,  1'b0, 32'h0,         32'h0,         1'b0, 1'b0}, // history -> 2
    '{2'd0, PCc, 1'b1, 32'hB000_0003, 32'hB000_0003, 1'b0, 1'b0},
    '{2'd1, PCc, 1'b0, 32'h0,         32'h8000_0003, 1'b0, 1'b0}, // R7 empty way1
    '{2'd0, PCc, 1'b1, 32'hB000_0003, 32'h8000_0003, 1'b1, 1'b1},
    '{2'd0, PD,  1'b1, 32'hB000_0004, 32'hB000_0004, 1'b0, 1'b0},
    '{2'd1, PD,  1'b0, 32'h0,         32'h8000_0004, 1'b0, 1'b0}, // R8 victim way0
    '{2'd0, PD,  1'b1, 32'hB000_0004, 32'h8000_0004, 1'b1, 1'b0},
    '{2'd0, PCc, 1'b1, 32'hB000_0003, 32'h8000_0003, 1'b1, 1'b1},
    '{2'd0, PE,  1'b1, 32'hB000_0005, 32'hB000_0005, 1'b0, 1'b0},
    '{2'd1, PE,  1'b0, 32'h0,         32'h8000_0005, 1'b0, 1'b0}, // R8 evicts D
    '{2'd0, PE,  1'b1, 32'hB000_0005, 32'h8000_0005, 1'b1, 1'b0},
    '{2'd0, PD,  1'b1, 32'hB000_0006, 32'hB000_0006, 1'b0, 1'b0}, // R7 D gone
    '{2'd1, PD,  1'b0, 32'h0,         32'h8000_0006, 1'b0, 1'b0}, // R8 evicts C
    '{2'd0, PD,  1'b1, 32'hB000_0006, 32'h8000_0006, 1'b1, 1'b1},
    '{2'd0, PCc, 1'b1, 32'hB000_0007, 32'hB000_0007, 1'b0, 1'b0},
    '{2'd0, PE,  1'b1, 32'hB000_0008, 32'h8000_0005, 1'b1, 1'b0},
    '{2'd1, PE,  1'b0, 32'h0,         32'h8000_0008, 1'b0, 1'b0}, // R6 in place
    '{2'd0, PE,  1'b1, 32'hB000_0008, 32'h8000_0008, 1'b1, 1'b0}, // R6 new target
    '{2'd0, PD,  1'b1, 32'hB000_0009, 32'h8000_0006, 1'b1, 1'b1}  // R6 neighbour kept
  };

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ghist == '0, "R1 history after reset", 64'(ghist), 64'h0);

    for (int i = 0; i < 27; i++) begin
      case (TBL[i].op)
        2'd0: lookup(TBL[i].pc, TBL[i].ind, TBL[i].btb, TBL[i].ehit, TBL[i].eway,
                     TBL[i].val, $sformatf("R4/R5 row %0d", i));
        2'd1: resolve(TBL[i].val);
        default: shift(TBL[i].val[0]);
      endcase
    end

    // R10: idle lookup port shows fallback even for a cached jump.
    @(negedge clk);
    idle();
    lk_pc = PE[31:2]; lk_is_ind = 1'b1; lk_btb_target = 32'hB000_00AA;
    #1;
    chk(lk_hit == 1'b0, "R10 hit while idle", 64'(lk_hit), 64'h0);
    chk(lk_target == 32'hB000_00AA, "R10 target while idle", 64'(lk_target), 64'hB000_00AA);
    // R10: the idle cycle must leave LRU alone; E still hits way0, D way1.
    lookup(PE, 1'b1, 32'hB000_00AB, 1'b1, 1'b0, 32'h8000_0008, "R10 state after idle");

    // R2: shifting sequence against the bench's history model.
    shift(1'b1); shift(1'b1); shift(1'b0); shift(1'b1);
    @(negedge clk);
    idle();
    #1;
    chk(ghist == mhist, "R2 history shift", 64'(ghist), 64'(mhist));
    @(negedge clk);
    #1;
    chk(ghist == mhist, "R2 history hold", 64'(ghist), 64'(mhist));

    // R1: reset mid-run clears entries and history.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mhist = '0;
    #1;
    chk(ghist == '0, "R1 history cleared", 64'(ghist), 64'h0);
    shift(1'b1); shift(1'b0);
    lookup(PE, 1'b1, 32'hB000_00CC, 1'b0, 1'b0, 32'hB000_00CC, "R1 entries cleared");

    @(negedge clk);
    idle();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule